// File: doc/BRIEF.md
# Write-Protected BCD Calendar Register Bank

This block is the timekeeping core of a real-time clock. It holds the time and date in eight byte-wide registers: seconds, minutes, hours, day of month, month, two-digit year, weekday and century. All of them except the weekday are packed BCD. A one-cycle pulse on `secTick` moves the calendar forward by one second. The carry runs through every field, and the length of each month is taken into account, including 29-day Februaries in years divisible by four.

A host reaches the bank through a simple byte-wide port with a shared address, a write strobe and a read strobe. Read data comes back one cycle after the read strobe. A status register holds a clock-failure flag and two write-enable latches. The calendar registers accept writes only after the host has written the status register twice, first with 0x02 and then with 0x06. Writing any other value, or the steps in the wrong order, locks them again. The hour byte keeps a mode bit (bit 7 set means 24-hour) that the counting never changes.

The eight calendar bytes sit at consecutive addresses, so a host can read the whole date and time with eight reads in a row.

Top module: `rtc_calendar_bank`

## Requirements
- R1: After reset the calendar reads sec 0x00, min 0x00, hour 0x80, day 0x01, month 0x01, year 0x00, weekday 0x00, century 0x20, and the status register reads 0x01 (clock-failure flag set, both latches clear).
- R2: Reads take one cycle. A read strobe sampled on a clock edge raises `rdValid` after that edge, and `rdData` then holds the value the register had before that edge. Addresses 0x30..0x37 hold sec, min, hour, day, month, year, weekday, century in that order. Address 0x3F is the status register {5'b0, bit2 second latch, bit1 first latch, bit0 failure flag}. Every other address reads 0x00.
- R3: Writing 0x02 to 0x3F sets the first latch and clears the second. A following write of 0x06 while the first latch is set sets both latches, and this unlocks the calendar.
- R4: Writing 0x06 to 0x3F while the first latch is clear clears both latches. Writing any value other than 0x02 or 0x06, including 0x00, also clears both latches.
- R5: A write to 0x30..0x37 while either latch is clear changes no register and leaves the failure flag as it was.
- R6: A write to 0x30..0x37 while both latches are set stores the byte (the weekday keeps only its low 3 bits) and clears the failure flag. The latches stay as they were.
- R7: Each tick increments seconds in BCD (0x09 goes to 0x10). Seconds roll 0x59 to 0x00 with a carry into minutes, and minutes roll 0x59 to 0x00 with a carry into hours.
- R8: The hour count in bits 5:0 runs 0x00..0x23 in BCD and rolls 0x23 to 0x00 with a carry into the day. Bits 7:6 of the hour byte never change on a tick.
- R9: The day rolls to 0x01 after 0x31 in months 01, 03, 05, 07, 08, 10 and 12, after 0x30 in months 04, 06, 09 and 11, and after 0x29 or 0x28 in month 02, depending on whether the year value is divisible by 4. The month rolls 0x12 to 0x01 with a carry into the year.
- R10: The year rolls 0x99 to 0x00 with a carry into the century, and the century rolls 0x99 to 0x00.
- R11: The weekday goes up by one, from 6 back to 0, only on a day rollover.
- R12: If a tick arrives in the same cycle as an accepted calendar write, the tick is dropped: the written register takes the new byte and every other calendar register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| busAddr | input | 6 | Register address for read or write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read byte |
| rdValid | output | 1 | High for one cycle when rdData is new |

## Verification
The properties assume that `secTick` is a single-cycle pulse. They also assume that a host never raises `wrEn` and `rdEn` in the same cycle. The stimulus drives every strobe for exactly one cycle, from the falling clock edge, and never overlaps reads with writes. The stimulus writes only legal BCD values into the calendar before it lets ticks arrive, because counting from a non-BCD value has no defined result. The one deliberate overlap of a tick with a write exists to exercise R12.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_CAL = 8;
  localparam int IDX_W   = $clog2(NUM_CAL);
  localparam int BYTE_W  = 8;

  // calendar field positions (the host depends on this order)
  localparam int SEC_I  = 0;
  localparam int MIN_I  = 1;
  localparam int HOUR_I = 2;
  localparam int DAY_I  = 3;
  localparam int MON_I  = 4;
  localparam int YEAR_I = 5;
  localparam int WDAY_I = 6;
  localparam int CENT_I = 7;

  // status byte encodings
  localparam logic [BYTE_W-1:0] STEP_ONE = 8'h02;
  localparam logic [BYTE_W-1:0] STEP_TWO = 8'h06;

  typedef struct packed {
    logic              calWr;
    logic [IDX_W-1:0]  calIdx;
    logic [BYTE_W-1:0] wrByte;
    logic              advance;
    logic              rdFire;
    logic              rdCal;
    logic              rdStat;
    logic [IDX_W-1:0]  rdIdx;
  } calStrobe_t;

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'h9) bcdInc = {v[7:4] + 4'd1, 4'h0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leapBcd(input logic [BYTE_W-1:0] yr);
    if (yr[4]) leapBcd = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    else       leapBcd = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
  endfunction

  function automatic logic [BYTE_W-1:0] monthEndBcd(input logic [BYTE_W-1:0] mon,
                                                    input logic [BYTE_W-1:0] yr);
    case (mon)
      8'h02:                      monthEndBcd = leapBcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthEndBcd = 8'h30;
      default:                    monthEndBcd = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] CAL_BASE  = 6'h30,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h3F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output calStrobe_t        strobe,
  output logic [BYTE_W-1:0] statusByte
);

  localparam logic [ADDR_W:0] CAL_LO = (ADDR_W+1)'(CAL_BASE);
  localparam logic [ADDR_W:0] CAL_HI = CAL_LO + (ADDR_W+1)'(NUM_CAL);

  logic failQ, welQ, rwelQ;
  logic inCal, isStat, unlocked, calAccept;
  logic [IDX_W-1:0] idx;

  assign inCal     = ({1'b0, busAddr} >= CAL_LO) && ({1'b0, busAddr} < CAL_HI);
  assign isStat    = (busAddr == STAT_ADDR);
  assign idx       = IDX_W'(busAddr - CAL_BASE);
  assign unlocked  = welQ && rwelQ;
  assign calAccept = wrEn && inCal && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failQ <= 1'b1;
      welQ  <= 1'b0;
      rwelQ <= 1'b0;
    end else begin
      if (wrEn && isStat) begin
        if (wrData == STEP_ONE) begin
          welQ  <= 1'b1;
          rwelQ <= 1'b0;
        end else if (wrData == STEP_TWO && welQ) begin
          rwelQ <= 1'b1;
        end else begin
          welQ  <= 1'b0;
          rwelQ <= 1'b0;
        end
      end
      if (calAccept) failQ <= 1'b0;
    end
  end

  assign statusByte = {5'b0, rwelQ, welQ, failQ};

  always_comb begin
    strobe.calWr   = calAccept;
    strobe.calIdx  = idx;
    strobe.wrByte  = wrData;
    strobe.advance = secTick && !calAccept;
    strobe.rdFire  = rdEn;
    strobe.rdCal   = inCal;
    strobe.rdStat  = isStat;
    strobe.rdIdx   = idx;
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CENT_RESET = 8'h20
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  calStrobe_t                strobe,
  input  logic [BYTE_W-1:0]         statusByte,
  output logic [BYTE_W-1:0]         rdData,
  output logic                      rdValid,
  output logic [NUM_CAL*BYTE_W-1:0] calFlat
);

  localparam logic [BYTE_W-1:0] RST_VAL [NUM_CAL] =
    '{8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, CENT_RESET};

  logic [BYTE_W-1:0] calQ  [NUM_CAL];
  logic [BYTE_W-1:0] nextQ [NUM_CAL];

  // carry chain
  logic secLast, minLast, hrLast, dayLast, monLast, yrLast, centLast;
  logic cSec, cMin, cHr, cDay, cMon, cYr, cCent;
  logic [BYTE_W-1:0] hrWide;

  always_comb begin
    secLast  = (calQ[SEC_I] == 8'h59);
    minLast  = (calQ[MIN_I] == 8'h59);
    hrLast   = (calQ[HOUR_I][5:0] == 6'h23);
    dayLast  = (calQ[DAY_I] == monthEndBcd(calQ[MON_I], calQ[YEAR_I]));
    monLast  = (calQ[MON_I] == 8'h12);
    yrLast   = (calQ[YEAR_I] == 8'h99);
    centLast = (calQ[CENT_I] == 8'h99);

    cSec  = strobe.advance;
    cMin  = cSec && secLast;
    cHr   = cMin && minLast;
    cDay  = cHr  && hrLast;
    cMon  = cDay && dayLast;
    cYr   = cMon && monLast;
    cCent = cYr  && yrLast;

    hrWide = bcdInc({2'b00, calQ[HOUR_I][5:0]});

    for (int i = 0; i < NUM_CAL; i++) nextQ[i] = calQ[i];

    if (cSec) nextQ[SEC_I] = secLast ? 8'h00 : bcdInc(calQ[SEC_I]);
    if (cMin) nextQ[MIN_I] = minLast ? 8'h00 : bcdInc(calQ[MIN_I]);
    if (cHr)  nextQ[HOUR_I] = {calQ[HOUR_I][7:6], hrLast ? 6'h00 : hrWide[5:0]};
    if (cDay) begin
      nextQ[DAY_I]  = dayLast ? 8'h01 : bcdInc(calQ[DAY_I]);
      nextQ[WDAY_I] = (calQ[WDAY_I][2:0] == 3'd6) ? 8'h00
                                                  : {5'b0, calQ[WDAY_I][2:0] + 3'd1};
    end
    if (cMon)  nextQ[MON_I]  = monLast ? 8'h01 : bcdInc(calQ[MON_I]);
    if (cYr)   nextQ[YEAR_I] = yrLast ? 8'h00 : bcdInc(calQ[YEAR_I]);
    if (cCent) nextQ[CENT_I] = centLast ? 8'h00 : bcdInc(calQ[CENT_I]);
  end

  // one register per field, write has priority over counting
  for (genvar g = 0; g < NUM_CAL; g++) begin : gField
    logic [BYTE_W-1:0] wrVal;
    if (g == WDAY_I) begin : gNarrow
      assign wrVal = {5'b0, strobe.wrByte[2:0]};
    end else begin : gFull
      assign wrVal = strobe.wrByte;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        calQ[g] <= RST_VAL[g];
      else if (strobe.calWr && strobe.calIdx == IDX_W'(g)) calQ[g] <= wrVal;
      else                                              calQ[g] <= nextQ[g];
    end

    assign calFlat[g*BYTE_W +: BYTE_W] = calQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdFire;
      if (strobe.rdFire) begin
        if (strobe.rdCal)       rdData <= calQ[strobe.rdIdx];
        else if (strobe.rdStat) rdData <= statusByte;
        else                    rdData <= '0;
      end
    end
  end

endmodule

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank
  import rtc_cal_pkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] CAL_BASE   = 6'h30,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 6'h3F,
  parameter logic [7:0]        CENT_RESET = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              rdValid
);

  calStrobe_t                strobe;
  logic [BYTE_W-1:0]         statusByte;
  logic [NUM_CAL*BYTE_W-1:0] calFlat;

  rtc_cal_ctrl #(
    .ADDR_W(ADDR_W), .CAL_BASE(CAL_BASE), .STAT_ADDR(STAT_ADDR)
  ) ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .strobe(strobe), .statusByte(statusByte)
  );

  rtc_cal_datapath #(
    .CENT_RESET(CENT_RESET)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusByte(statusByte),
    .rdData(rdData), .rdValid(rdValid), .calFlat(calFlat)
  );

endmodule

// File: rtl/rtc_calendar_bank_chk.sv
module rtc_calendar_bank_chk #(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] CAL_BASE  = 6'h30,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h3F
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic              rdEn,
  input logic              rdValid,
  input logic [2:0]        stat,
  input logic [63:0]       calFlat
);

  localparam logic [ADDR_W:0] CAL_LO = (ADDR_W+1)'(CAL_BASE);
  localparam logic [ADDR_W:0] CAL_HI = CAL_LO + (ADDR_W+1)'(8);

  logic isCal, isStat, open;
  assign isCal  = ({1'b0, busAddr} >= CAL_LO) && ({1'b0, busAddr} < CAL_HI);
  assign isStat = (busAddr == STAT_ADDR);
  assign open   = (stat[2:1] == 2'b11);

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R2
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R3
  second_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat[2]) |-> $past(wrEn && isStat && wrData == 8'h06 && stat[1]));

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isStat && wrData == 8'h00) |=> (stat[2:1] == 2'b00));

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCal && !open && !secTick) |=> $stable(calFlat));

  // R6
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stat[0]) |-> $past(wrEn && isCal && open));

  // R8
  hour_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !wrEn) |=> $stable(calFlat[23:22]));

  // R12
  wr_beats_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && wrEn && isCal && open && busAddr != CAL_BASE) |=> $stable(calFlat[7:0]));

endmodule

bind rtc_calendar_bank rtc_calendar_bank_chk #(
  .ADDR_W(ADDR_W), .CAL_BASE(CAL_BASE), .STAT_ADDR(STAT_ADDR)
) chkInst (
  .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
  .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdValid(rdValid),
  .stat(statusByte[2:0]), .calFlat(calFlat)
);

// File: tb/rtc_calendar_bank_test.sv
module rtc_calendar_bank_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [5:0] busAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       rdValid;

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  rtc_calendar_bank uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid)
  );

  // monitor: pops one expectation per returned byte
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R2 unrequested read: got %02h expected no data", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          mismatched++;
          $display("FAIL %s: got %02h expected %02h", t, rdData, e);
        end
      end
    end
  end

  function automatic logic [63:0] cal(input logic [7:0] sec, mn, hr, day, mon, yr, wd, cent);
    return {cent, wd, yr, mon, day, hr, mn, sec};
  endfunction

  task automatic wrReg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setCal(input logic [63:0] v);
    for (int i = 0; i < 8; i++) wrReg(6'(6'h30 + i), v[i*8 +: 8]);
  endtask

  task automatic checkCal(input logic [63:0] v, input string tag);
    for (int i = 0; i < 8; i++)
      rdReg(6'(6'h30 + i), v[i*8 +: 8], $sformatf("%s byte %0d", tag, i));
  endtask

  task automatic tickAndCheck(input logic [63:0] start, input logic [63:0] want, input string tag);
    setCal(start);
    tickOnce();
    checkCal(want, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    checkCal(cal(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20), "R1 reset calendar");
    rdReg(6'h3F, 8'h01, "R1 reset status");
    // R2 unmapped address
    rdReg(6'h20, 8'h00, "R2 unmapped address");

    // R5 locked write
    wrReg(6'h30, 8'h45);
    rdReg(6'h30, 8'h00, "R5 locked write ignored");
    rdReg(6'h3F, 8'h01, "R5 failure flag kept");

    // R4 out-of-order step
    wrReg(6'h3F, 8'h06);
    rdReg(6'h3F, 8'h01, "R4 second step first");
    // R3 first step
    wrReg(6'h3F, 8'h02);
    rdReg(6'h3F, 8'h03, "R3 first step");
    wrReg(6'h31, 8'h12);
    rdReg(6'h31, 8'h00, "R5 half unlocked write ignored");
    // R4 stray value
    wrReg(6'h3F, 8'h05);
    rdReg(6'h3F, 8'h01, "R4 stray value relocks");
    wrReg(6'h3F, 8'h02);
    wrReg(6'h3F, 8'h06);
    rdReg(6'h3F, 8'h07, "R3 both latches");

    // R6 store, weekday mask, failure flag clears
    setCal(cal(8'h58, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'hFD, 8'h20));
    checkCal(cal(8'h58, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h05, 8'h20), "R6 stored");
    rdReg(6'h3F, 8'h06, "R6 failure flag cleared");
    wrReg(6'h3F, 8'h00);
    rdReg(6'h3F, 8'h00, "R4 zero relocks");

    // R7 / R8 / R9 / R11 while locked: ticks still count
    tickOnce();
    checkCal(cal(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h05, 8'h20), "R7 plain second");
    tickOnce();
    checkCal(cal(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, 8'h06, 8'h20), "R9 common-year february");
    tickOnce();
    checkCal(cal(8'h01, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, 8'h06, 8'h20), "R11 weekday held");
    wrReg(6'h30, 8'h11);
    rdReg(6'h30, 8'h01, "R5 relocked write ignored");

    wrReg(6'h3F, 8'h02);
    wrReg(6'h3F, 8'h06);

    tickAndCheck(cal(8'h09, 8'h45, 8'h99, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20),
                 cal(8'h10, 8'h45, 8'h99, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20), "R7 ones carry");
    tickAndCheck(cal(8'h59, 8'h45, 8'h99, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20),
                 cal(8'h00, 8'h46, 8'h99, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20), "R7 minute carry");
    tickAndCheck(cal(8'h59, 8'h59, 8'h99, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20),
                 cal(8'h00, 8'h00, 8'hA0, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20), "R8 hour tens carry");
    tickAndCheck(cal(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h24, 8'h02, 8'h20),
                 cal(8'h00, 8'h00, 8'h00, 8'h16, 8'h06, 8'h24, 8'h03, 8'h20), "R8 mode bit clear kept");
    tickAndCheck(cal(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h06, 8'h20),
                 cal(8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h24, 8'h00, 8'h20), "R9 R11 leap february 28");
    tickAndCheck(cal(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 8'h00, 8'h20),
                 cal(8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h24, 8'h01, 8'h20), "R9 leap february 29");
    tickAndCheck(cal(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h24, 8'h01, 8'h20),
                 cal(8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h24, 8'h02, 8'h20), "R9 thirty-day month");
    tickAndCheck(cal(8'h59, 8'h59, 8'hA3, 8'h30, 8'h05, 8'h24, 8'h02, 8'h20),
                 cal(8'h00, 8'h00, 8'h80, 8'h31, 8'h05, 8'h24, 8'h03, 8'h20), "R9 thirty-one-day month");
    tickAndCheck(cal(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h03, 8'h20),
                 cal(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h04, 8'h21), "R10 year wrap");
    tickAndCheck(cal(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h04, 8'h99),
                 cal(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h05, 8'h00), "R10 century wrap");

    // R12 write and tick in one cycle
    setCal(cal(8'h10, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h01, 8'h20));
    @(negedge clk);
    busAddr = 6'h31; wrData = 8'h33; wrEn = 1'b1; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    checkCal(cal(8'h10, 8'h33, 8'h85, 8'h05, 8'h05, 8'h25, 8'h01, 8'h20), "R12 write beats tick");
    tickOnce();
    rdReg(6'h30, 8'h11, "R12 ticks resume");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R2 missing reads: got %0d outstanding expected 0", expQ.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule